// File: doc/BRIEF.md
# Banked Memory Region Dispatcher

This block takes byte and word requests over a 20-bit address space and routes each one to a backing target. It splits the space into 32 regions of 32 KB, and the region number is address bits 19:15. The possible targets are main RAM, a four-plane graphics store, a paged expanded-memory window, an upper ROM area with an optional RAM shadow, and a sink for unmapped space. Every backing store is modelled inside the block and is aliased onto a small parameterised depth. Words are little-endian: the low byte lives at the request address and the high byte at the next address.

Requests use a valid/ready handshake. When `req_ready` is high, a request with `req_valid` high is accepted on the clock edge. A word that stays inside one target runs in a single cycle. A word that crosses a 32 KB region edge, or a 16 KB page edge inside the expanded-memory window, runs as two byte cycles, low byte first, and each byte is decoded in its own region. During the second byte cycle `req_ready` is low, and that is the only back-pressure the block applies.

The response is a single-cycle `rsp_valid` pulse and cannot be stalled, so the requester must always take it. Four control pins select the routing at run time: the installed RAM size, digital or analog graphics mode, ROM or shadow mode, and the shadow read bank. These pins must be held stable while a split word is in flight.

Top module: `memregion_router`

## Requirements
- R1: Regions 0 up to `ram_top`-1 are main RAM. Data written there reads back unchanged. A word stores its low byte at the request address and its high byte at the address plus one.
- R2: While `rst_n` is low, `req_ready` is 1 and `rsp_valid` is 0. Every backing store reads 0 after reset.
- R3: A request is accepted when `req_valid` and `req_ready` are both high. An accepted byte request, or a word request that does not split, gives `rsp_valid` high in the next cycle, and `req_ready` stays high.
- R4: A word request whose address bits 14:0 are 0x7FFF is split. In the cycle after acceptance, `req_ready` and `rsp_valid` are both 0, and `rsp_valid` comes one cycle later. The high byte goes to the following region.
- R5: Regions 24 and 25 form the expanded-memory window. Address bits 15:14 pick one of four 16 KB pages. A word at page offset 0x3FFF is split: its high byte lands at offset 0 of the next page.
- R6: Region 28 is graphics plane 3 when `digital_mode` is 0. When `digital_mode` is 1, that region reads 0xFF per byte (0xFFFF for a word) and writes to it are dropped. Regions 21, 22 and 23 are graphics planes 0, 1 and 2.
- R7: Region 20, regions 26 and 27, and RAM regions at or above `ram_top` are unmapped. They read 0xFF per byte and drop writes.
- R8: When `shadow_en` is 0, regions 29 to 31 are ROM. A byte at address A reads A[7:0] ^ A[15:8] ^ 0x5A, and writes are dropped.
- R9: When `shadow_en` is 1, writes to regions 29 to 31 go to a backing RAM at index (A - 0xE8000). Reads return that backing RAM when `bank_sel` is 1 and the ROM pattern when `bank_sel` is 0.
- R10: A byte read returns its data in `rsp_rdata[7:0]` with `rsp_rdata[15:8]` = 0. Every write response carries `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ram_top | input | 5 | First region number not backed by installed RAM |
| digital_mode | input | 1 | 1 disables graphics region 28 |
| shadow_en | input | 1 | 1 redirects upper-area writes to the shadow RAM |
| bank_sel | input | 1 | Shadow mode: 1 reads the shadow RAM, 0 reads ROM |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word access, 0 byte access |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |

## Verification
The checker watches handshake timing on every cycle:
- a single-cycle response after each non-split acceptance;
- the stall and delayed response after a split;
- the absence of unrequested responses;
- the fixed values returned by unmapped space, by the disabled graphics region and in the upper byte of byte reads.

Only the bench scenarios can show that stored data reaches the right target and page, that dropped writes really leave storage untouched, and that shadow redirection and bank selection work. Those checks need a history of writes compared against later reads.

// File: rtl/memrt_pkg.sv
package memrt_pkg;
  localparam int ADDR_W   = 20;
  localparam int REGION_W = 5;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_GFX,
    TGT_EMS,
    TGT_ROM,
    TGT_SHD
  } tgt_e;

  localparam logic [REGION_W-1:0] RG_TEXT     = 5'd20;
  localparam logic [REGION_W-1:0] RG_GFX_A    = 5'd21;
  localparam logic [REGION_W-1:0] RG_GFX_B    = 5'd22;
  localparam logic [REGION_W-1:0] RG_GFX_C    = 5'd23;
  localparam logic [REGION_W-1:0] RG_EMS_LO   = 5'd24;
  localparam logic [REGION_W-1:0] RG_EMS_HI   = 5'd25;
  localparam logic [REGION_W-1:0] RG_GFX_D    = 5'd28;
  localparam logic [REGION_W-1:0] RG_UPPER_LO = 5'd29;
  localparam logic [ADDR_W-1:0]   SHADOW_BASE = 20'hE8000;

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic need_split(input logic [ADDR_W-1:0] a);
    logic in_ems;
    in_ems = (a[19:15] == RG_EMS_LO) || (a[19:15] == RG_EMS_HI);
    return (a[14:0] == 15'h7FFF) || (in_ems && (a[13:0] == 14'h3FFF));
  endfunction
endpackage

// File: rtl/memrt_region_decode.sv
module memrt_region_decode
  import memrt_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int GFX_AW = 8,
  parameter int EMS_AW = 8,
  parameter int SHD_AW = 9
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                is_wr,
  input  logic [REGION_W-1:0] ram_top,
  input  logic                digital_mode,
  input  logic                shadow_en,
  input  logic                bank_sel,
  output tgt_e                tgt,
  output logic [RAM_AW-1:0]   ram_idx,
  output logic [GFX_AW+1:0]   gfx_idx,
  output logic [EMS_AW+1:0]   ems_idx,
  output logic [SHD_AW-1:0]   shd_idx,
  output logic [7:0]          rom_data
);
  logic [REGION_W-1:0] region;
  logic [1:0]          plane;

  assign region = addr[ADDR_W-1 -: REGION_W];

  always_comb begin
    tgt   = TGT_NONE;
    plane = 2'd0;
    if (region < RG_TEXT) begin
      tgt = (region < ram_top) ? TGT_RAM : TGT_NONE;
    end else begin
      case (region)
        RG_GFX_A: begin tgt = TGT_GFX; plane = 2'd0; end
        RG_GFX_B: begin tgt = TGT_GFX; plane = 2'd1; end
        RG_GFX_C: begin tgt = TGT_GFX; plane = 2'd2; end
        RG_GFX_D: begin
          tgt   = digital_mode ? TGT_NONE : TGT_GFX;
          plane = 2'd3;
        end
        RG_EMS_LO, RG_EMS_HI: tgt = TGT_EMS;
        default: begin
          if (region >= RG_UPPER_LO) begin
            if (is_wr) tgt = shadow_en ? TGT_SHD : TGT_NONE;
            else       tgt = (shadow_en && bank_sel) ? TGT_SHD : TGT_ROM;
          end
        end
      endcase
    end
  end

  assign ram_idx  = addr[RAM_AW-1:0];
  assign gfx_idx  = {plane, addr[GFX_AW-1:0]};
  assign ems_idx  = {addr[15:14], addr[EMS_AW-1:0]};
  assign shd_idx  = SHD_AW'(addr - SHADOW_BASE);
  assign rom_data = rom_byte(addr[15:0]);
endmodule

// File: rtl/memrt_byte_store.sv
module memrt_byte_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [7:0]    wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [7:0]    wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [7:0]    rd0,
  output logic [7:0]    rd1
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else begin
      if (we0) cells[wa0] <= wd0;
      if (we1) cells[wa1] <= wd1;
    end
  end

  assign rd0 = cells[ra0];
  assign rd1 = cells[ra1];
endmodule

// File: rtl/memregion_router.sv
module memregion_router
  import memrt_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int GFX_AW = 8,
  parameter int EMS_AW = 8,
  parameter int SHD_AW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REGION_W-1:0] ram_top,
  input  logic                digital_mode,
  input  logic                shadow_en,
  input  logic                bank_sel,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [15:0]         req_wdata,
  output logic                rsp_valid,
  output logic [15:0]         rsp_rdata
);
  localparam int LANES = 2;
  localparam int GFX_IW = GFX_AW + 2;
  localparam int EMS_IW = EMS_AW + 2;

  typedef enum logic {ST_IDLE, ST_HIGH} st_e;

  st_e               state;
  logic [ADDR_W-1:0] hold_addr;
  logic [7:0]        hold_hi;
  logic              hold_wr;
  logic [7:0]        lo_byte;

  logic accept;
  logic split_now;
  logic op_wr;

  logic [ADDR_W-1:0] ln_addr [LANES];
  logic              ln_en   [LANES];
  logic [7:0]        ln_wd   [LANES];
  tgt_e              ln_tgt  [LANES];
  logic [RAM_AW-1:0] ln_ram  [LANES];
  logic [GFX_IW-1:0] ln_gfx  [LANES];
  logic [EMS_IW-1:0] ln_ems  [LANES];
  logic [SHD_AW-1:0] ln_shd  [LANES];
  logic [7:0]        ln_rom  [LANES];
  logic [7:0]        ln_rd   [LANES];
  logic [7:0]        ram_rd  [LANES];
  logic [7:0]        gfx_rd  [LANES];
  logic [7:0]        ems_rd  [LANES];
  logic [7:0]        shd_rd  [LANES];
  logic              we_ram  [LANES];
  logic              we_gfx  [LANES];
  logic              we_ems  [LANES];
  logic              we_shd  [LANES];

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign split_now = req_word && need_split(req_addr);

  always_comb begin
    if (state == ST_HIGH) begin
      op_wr      = hold_wr;
      ln_addr[0] = hold_addr;
      ln_addr[1] = hold_addr;
      ln_en[0]   = 1'b1;
      ln_en[1]   = 1'b0;
      ln_wd[0]   = hold_hi;
      ln_wd[1]   = 8'h00;
    end else begin
      op_wr      = req_write;
      ln_addr[0] = req_addr;
      ln_addr[1] = req_addr + 20'd1;
      ln_en[0]   = accept;
      ln_en[1]   = accept && req_word && !split_now;
      ln_wd[0]   = req_wdata[7:0];
      ln_wd[1]   = req_wdata[15:8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    memrt_region_decode #(
      .RAM_AW(RAM_AW), .GFX_AW(GFX_AW), .EMS_AW(EMS_AW), .SHD_AW(SHD_AW)
    ) u_dec (
      .addr        (ln_addr[g]),
      .is_wr       (op_wr),
      .ram_top     (ram_top),
      .digital_mode(digital_mode),
      .shadow_en   (shadow_en),
      .bank_sel    (bank_sel),
      .tgt         (ln_tgt[g]),
      .ram_idx     (ln_ram[g]),
      .gfx_idx     (ln_gfx[g]),
      .ems_idx     (ln_ems[g]),
      .shd_idx     (ln_shd[g]),
      .rom_data    (ln_rom[g])
    );

    assign we_ram[g] = ln_en[g] && op_wr && (ln_tgt[g] == TGT_RAM);
    assign we_gfx[g] = ln_en[g] && op_wr && (ln_tgt[g] == TGT_GFX);
    assign we_ems[g] = ln_en[g] && op_wr && (ln_tgt[g] == TGT_EMS);
    assign we_shd[g] = ln_en[g] && op_wr && (ln_tgt[g] == TGT_SHD);

    always_comb begin
      case (ln_tgt[g])
        TGT_RAM: ln_rd[g] = ram_rd[g];
        TGT_GFX: ln_rd[g] = gfx_rd[g];
        TGT_EMS: ln_rd[g] = ems_rd[g];
        TGT_ROM: ln_rd[g] = ln_rom[g];
        TGT_SHD: ln_rd[g] = shd_rd[g];
        default: ln_rd[g] = 8'hFF;
      endcase
    end
  end

  memrt_byte_store #(.AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we0(we_ram[0]), .wa0(ln_ram[0]), .wd0(ln_wd[0]),
    .we1(we_ram[1]), .wa1(ln_ram[1]), .wd1(ln_wd[1]),
    .ra0(ln_ram[0]), .ra1(ln_ram[1]), .rd0(ram_rd[0]), .rd1(ram_rd[1])
  );

  memrt_byte_store #(.AW(GFX_IW)) u_gfx (
    .clk(clk), .rst_n(rst_n),
    .we0(we_gfx[0]), .wa0(ln_gfx[0]), .wd0(ln_wd[0]),
    .we1(we_gfx[1]), .wa1(ln_gfx[1]), .wd1(ln_wd[1]),
    .ra0(ln_gfx[0]), .ra1(ln_gfx[1]), .rd0(gfx_rd[0]), .rd1(gfx_rd[1])
  );

  memrt_byte_store #(.AW(EMS_IW)) u_ems (
    .clk(clk), .rst_n(rst_n),
    .we0(we_ems[0]), .wa0(ln_ems[0]), .wd0(ln_wd[0]),
    .we1(we_ems[1]), .wa1(ln_ems[1]), .wd1(ln_wd[1]),
    .ra0(ln_ems[0]), .ra1(ln_ems[1]), .rd0(ems_rd[0]), .rd1(ems_rd[1])
  );

  memrt_byte_store #(.AW(SHD_AW)) u_shd (
    .clk(clk), .rst_n(rst_n),
    .we0(we_shd[0]), .wa0(ln_shd[0]), .wd0(ln_wd[0]),
    .we1(we_shd[1]), .wa1(ln_shd[1]), .wd1(ln_wd[1]),
    .ra0(ln_shd[0]), .ra1(ln_shd[1]), .rd0(shd_rd[0]), .rd1(shd_rd[1])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hold_addr <= '0;
      hold_hi   <= 8'h00;
      hold_wr   <= 1'b0;
      lo_byte   <= 8'h00;
      rsp_valid <= 1'b0;
      rsp_rdata <= 16'h0000;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (split_now) begin
              state     <= ST_HIGH;
              hold_addr <= req_addr + 20'd1;
              hold_hi   <= req_wdata[15:8];
              hold_wr   <= req_write;
              lo_byte   <= ln_rd[0];
            end else begin
              rsp_valid <= 1'b1;
              if (req_write)     rsp_rdata <= 16'h0000;
              else if (req_word) rsp_rdata <= {ln_rd[1], ln_rd[0]};
              else               rsp_rdata <= {8'h00, ln_rd[0]};
            end
          end
        end
        default: begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= hold_wr ? 16'h0000 : {ln_rd[0], lo_byte};
        end
      endcase
    end
  end
endmodule

// File: rtl/memrt_checker.sv
module memrt_checker
  import memrt_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                digital_mode,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                req_word,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                rsp_valid,
  input logic [15:0]         rsp_rdata
);
  logic acc;
  logic spl;
  assign acc = req_valid && req_ready;
  assign spl = req_word && need_split(req_addr);

  a_r2_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && req_ready));

  a_r3_single_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !spl) |=> (rsp_valid && req_ready));

  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(acc) || $past(!req_ready)));

  a_r4_split_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && spl) |=> (!req_ready && !rsp_valid));

  a_r4_split_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && spl) |=> ##1 (rsp_valid && req_ready));

  a_r6_digital_word: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_word && !spl && digital_mode &&
     req_addr[19:15] == RG_GFX_D) |=> (rsp_rdata == 16'hFFFF));

  a_r7_unmapped_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !req_word && req_addr[19:15] == RG_TEXT)
    |=> (rsp_rdata == 16'h00FF));

  a_r10_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !req_word) |=> (rsp_rdata[15:8] == 8'h00));
endmodule

bind memregion_router memrt_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .digital_mode(digital_mode),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_word    (req_word),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata)
);

// File: tb/memregion_router_tb.sv
module memregion_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ram_top = 5'd20;
  logic        digital_mode = 1'b0;
  logic        shadow_en = 1'b0;
  logic        bank_sel = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_ram [1024];
  logic [7:0] m_gfx [1024];
  logic [7:0] m_ems [1024];
  logic [7:0] m_shd [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  memregion_router u_dut (
    .clk(clk), .rst_n(rst_n), .ram_top(ram_top), .digital_mode(digital_mode),
    .shadow_en(shadow_en), .bank_sel(bank_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string rq, input logic [15:0] act,
                       input logic [15:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  function automatic int gfx_plane(input logic [4:0] rg);
    case (rg)
      5'd21: return 0;
      5'd22: return 1;
      5'd23: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input logic [19:0] a);
    logic [4:0]  rg;
    logic [19:0] so;
    rg = a[19:15];
    so = a - 20'hE8000;
    if (rg < 5'd20) return (rg < ram_top) ? m_ram[a[9:0]] : 8'hFF;
    if (rg >= 5'd21 && rg <= 5'd23) return m_gfx[gfx_plane(rg)*256 + int'(a[7:0])];
    if (rg == 5'd28) return digital_mode ? 8'hFF : m_gfx[768 + int'(a[7:0])];
    if (rg == 5'd24 || rg == 5'd25) return m_ems[int'(a[15:14])*256 + int'(a[7:0])];
    if (rg >= 5'd29) begin
      if (shadow_en && bank_sel) return m_shd[so[8:0]];
      return a[7:0] ^ a[15:8] ^ 8'h5A;
    end
    return 8'hFF;
  endfunction

  task automatic model_wr(input logic [19:0] a, input logic [7:0] d);
    logic [4:0]  rg;
    logic [19:0] so;
    rg = a[19:15];
    so = a - 20'hE8000;
    if (rg < 5'd20) begin
      if (rg < ram_top) m_ram[a[9:0]] = d;
    end else if (rg >= 5'd21 && rg <= 5'd23) begin
      m_gfx[gfx_plane(rg)*256 + int'(a[7:0])] = d;
    end else if (rg == 5'd28) begin
      if (!digital_mode) m_gfx[768 + int'(a[7:0])] = d;
    end else if (rg == 5'd24 || rg == 5'd25) begin
      m_ems[int'(a[15:14])*256 + int'(a[7:0])] = d;
    end else if (rg >= 5'd29) begin
      if (shadow_en) m_shd[so[8:0]] = d;
    end
  endtask

  function automatic bit bench_split(input logic [19:0] a);
    bit ems;
    ems = (a[19:15] == 5'd24) || (a[19:15] == 5'd25);
    return (a[14:0] == 15'h7FFF) || (ems && a[13:0] == 14'h3FFF);
  endfunction

  function automatic string tag_of(input logic [19:0] a, input bit sp);
    logic [4:0] rg;
    rg = a[19:15];
    if (rg == 5'd24 || rg == 5'd25) return "R5";
    if (sp) return "R4";
    if (rg < 5'd20) return (rg < ram_top) ? "R1" : "R7";
    if (rg == 5'd28) return "R6";
    if (rg >= 5'd21 && rg <= 5'd23) return "R6";
    if (rg >= 5'd29) return shadow_en ? "R9" : "R8";
    return "R7";
  endfunction

  task automatic xfer(input bit wr, input bit wd, input logic [19:0] a,
                      input logic [15:0] d);
    bit          sp;
    string       tg;
    logic [15:0] exp_d;
    sp = wd && bench_split(a);
    tg = tag_of(a, sp);
    if (wr)      exp_d = 16'h0000;
    else if (wd) exp_d = {model_rd(a + 20'd1), model_rd(a)};
    else         exp_d = {8'h00, model_rd(a)};
    if (wr) begin
      model_wr(a, d[7:0]);
      if (wd) model_wr(a + 20'd1, d[15:8]);
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (sp) begin
      check(!req_ready && !rsp_valid, "R4 stall", {14'b0, req_ready, rsp_valid}, 16'h0);
      @(negedge clk);
    end
    check(rsp_valid && req_ready, sp ? "R4 rsp" : "R3 rsp",
          {14'b0, req_ready, rsp_valid}, 16'h3);
    if (wr) check(rsp_rdata == 16'h0, "R10 wr rsp", rsp_rdata, 16'h0);
    else    check(rsp_rdata == exp_d, tg, rsp_rdata, exp_d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] a;
    logic [4:0]  rg;
    logic [14:0] ofs;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin m_ram[i] = 0; m_gfx[i] = 0; m_ems[i] = 0; end
    for (int i = 0; i < 512; i++) m_shd[i] = 0;

    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid, "R2 reset", {14'b0, req_ready, rsp_valid}, 16'h2);
    rst_n = 1'b1;
    @(negedge clk);

    xfer(0, 0, 20'h00010, 16'h0);               // R2 cleared store
    xfer(1, 1, 20'h01234, 16'hBEEF);            // R1
    xfer(0, 0, 20'h01234, 16'h0);               // R1 low byte, R10
    xfer(0, 1, 20'h01234, 16'h0);               // R1
    xfer(1, 1, 20'h07FFF, 16'hA1B2);            // R4
    xfer(0, 0, 20'h07FFF, 16'h0);
    xfer(0, 0, 20'h08000, 16'h0);
    xfer(0, 1, 20'h07FFF, 16'h0);
    xfer(1, 1, 20'hC3FFF, 16'h1234);            // R5 page split
    xfer(0, 0, 20'hC4000, 16'h0);
    xfer(0, 1, 20'hC3FFF, 16'h0);
    xfer(1, 0, 20'hCC005, 16'h0077);            // R5 page 3
    xfer(0, 0, 20'hCC005, 16'h0);
    @(negedge clk); digital_mode = 1'b1;
    xfer(1, 1, 20'hE0010, 16'h5555);            // R6 dropped
    xfer(0, 1, 20'hE0010, 16'h0);
    @(negedge clk); digital_mode = 1'b0;
    xfer(0, 1, 20'hE0010, 16'h0);               // R6 still zero
    xfer(1, 1, 20'hE0010, 16'h6789);
    xfer(0, 1, 20'hE0010, 16'h0);
    xfer(1, 0, 20'hA0004, 16'h0012);            // R7
    xfer(0, 0, 20'hA0004, 16'h0);
    xfer(0, 1, 20'hD0100, 16'h0);
    @(negedge clk); ram_top = 5'd4;
    xfer(1, 0, 20'h20001, 16'h0033);
    xfer(0, 0, 20'h20001, 16'h0);               // R7 above installed RAM
    @(negedge clk); ram_top = 5'd20;
    xfer(0, 0, 20'h20001, 16'h0);
    xfer(0, 1, 20'hF1234, 16'h0);               // R8
    xfer(1, 1, 20'hF1234, 16'hFFFF);
    xfer(0, 1, 20'hF1234, 16'h0);
    @(negedge clk); shadow_en = 1'b1; bank_sel = 1'b0;
    xfer(1, 1, 20'hF0010, 16'h7711);            // R9
    xfer(0, 1, 20'hF0010, 16'h0);
    @(negedge clk); bank_sel = 1'b1;
    xfer(0, 1, 20'hF0010, 16'h0);
    xfer(0, 1, 20'hFFFFF, 16'h0);               // R4 wrap across top

    for (int n = 0; n < N_RANDOM; n++) begin
      if (n % 50 == 0) begin
        @(negedge clk);
        digital_mode = 1'($urandom);
        shadow_en    = 1'($urandom);
        bank_sel     = 1'($urandom);
        ram_top      = 5'(4 + $urandom % 17);
      end
      case ($urandom % 8)
        0: rg = 5'($urandom % 20);
        1: rg = ($urandom % 2) ? 5'd20 : 5'(26 + $urandom % 2);
        2: rg = 5'(21 + $urandom % 3);
        3: rg = 5'd28;
        4: rg = 5'(24 + $urandom % 2);
        5: rg = 5'(29 + $urandom % 3);
        default: rg = 5'($urandom % 8);
      endcase
      case ($urandom % 8)
        0: ofs = 15'h7FFF;
        1: ofs = {1'($urandom), 14'h3FFF};
        default: ofs = 15'($urandom) & 15'h401F;
      endcase
      a = {rg, ofs};
      xfer(1'($urandom), 1'($urandom), a, 16'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule